// File: doc/BRIEF.md
# DMA Address and Word Counter

This block keeps the pointer and the remaining-length count for one data-transfer channel of a disk or tape controller. Software loads a 16-bit word count, held as the two's-complement negative of the number of words to move, a 16-bit bus address, and a control word. The control word holds two address extension bits and an increment-inhibit bit. The extension bits sit above the 16-bit address and together with it form an 18-bit bus address.

A data path raises `xfer_req` for each word it wants to move. When the count is nonzero the block asks for the bus and presents the 18-bit address. On `bus_ack` it steps the count toward zero and, unless inhibited, moves the address forward. A narrow word advances the count by one and the address by two. A wide 36-bit word advances them by two and four. When the count is already zero the block raises `zero_count` and requests nothing. A sticky `done` flag marks the step that brings the count to zero.

Top module: `dma_addr_counter`

## Requirements
- R1: After a synchronous active-low reset, `word_count`, `bus_addr`, `incr_inhibit` and `done` are all zero.
- R2: A host write with `cfg_sel` 0 loads the word count, `cfg_sel` 1 loads the low 16 address bits, and `cfg_sel` 2 loads the extension bits from `cfg_wdata[1:0]` and the increment-inhibit bit from `cfg_wdata[2]`. `bus_addr` is the extension bits placed at bits 17:16 over the 16-bit address.
- R3: While `xfer_req` is high and the count is zero, `bus_req` is low, `zero_count` is high, and an acknowledge changes neither count nor address. With a nonzero count, `bus_req` follows `xfer_req` and `zero_count` is low.
- R4: A narrow transfer (`xfer_wide`=0) acknowledged at a clock edge adds 1 to the count and 2 to the address at that edge.
- R5: A wide transfer (`xfer_wide`=1) acknowledged at a clock edge adds 2 to the count and 4 to the address at that edge.
- R6: With the inhibit bit set and `xfer_force` low, an acknowledged transfer advances the count but leaves the address unchanged. With `xfer_force` high, the address advances as if uninhibited.
- R7: A carry out of bit 15 of the address increments the extension bits. A carry out of bit 17 is dropped, so the address wraps to zero.
- R8: `done` rises at the edge where an acknowledged step leaves the count at zero. It stays high through other writes and clears only when the count is loaded.
- R9: A host count load in the same cycle as an acknowledge wins over the count step, while the address still advances.
- R10: `bus_ack` while `bus_req` is low has no effect on count, address or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register select: 0 count, 1 address, 2 control |
| cfg_wdata | input | 16 | Host write data |
| xfer_req | input | 1 | Data path wants to move one word |
| xfer_wide | input | 1 | Requested word is 36 bits wide |
| xfer_force | input | 1 | Advance the address even when inhibited |
| bus_ack | input | 1 | Bus access accepted this cycle |
| bus_req | output | 1 | Bus access request |
| bus_wide | output | 1 | Width of the requested access |
| bus_addr | output | 18 | Current 18-bit bus address |
| zero_count | output | 1 | Transfer requested with zero count |
| word_count | output | 16 | Current word count |
| incr_inhibit | output | 1 | Address increment inhibit bit |
| done | output | 1 | Count reached zero by a step |

## Verification
The bench builds the block with its default widths: a 16-bit count, a 16-bit address and two extension bits, with steps of one and two words. These widths make the carry from address bit 15 into the extension field, and the wrap past bit 17, reachable with a single write and one transfer. A wide step taken from a count of -2 reaches zero exactly, so `done` is exercised by both transfer widths. The collision between a count load and an acknowledge is driven in the same cycle to show which source takes priority.

// File: rtl/dma_cnt_pkg.sv
// Package: shared select codes for the DMA address and word counter.
// Assumes a two-bit register select on the host port.
package dma_cnt_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/dma_req_ctrl.sv
// Module: dma_req_ctrl
// Decides whether a transfer request turns into a bus request or into a
// zero-count report, and produces the one-cycle step strobe on acknowledge.
// Assumes bus_ack is only meaningful while bus_req is high.
module dma_req_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             xfer_req,
    input  logic [CNT_W-1:0] count,
    input  logic             bus_ack,
    output logic             bus_req,
    output logic             zero_count,
    output logic             step_en
);

    logic count_is_zero;

    // Classify the request against the current count.
    always_comb begin
        count_is_zero = (count == '0);
        bus_req       = xfer_req && !count_is_zero;
        zero_count    = xfer_req && count_is_zero;
        step_en       = bus_req && bus_ack;
    end

endmodule

// File: rtl/dma_count_unit.sv
// Module: dma_count_unit
// Holds the up-counting word count and the sticky done flag.
// Assumes a host load has priority over a step in the same cycle.
module dma_count_unit #(
    parameter int CNT_W       = 16,
    parameter int NARROW_STEP = 1,
    parameter int WIDE_STEP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step_en,
    input  logic             step_wide,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] INC_N = CNT_W'(NARROW_STEP);
    localparam logic [CNT_W-1:0] INC_W = CNT_W'(WIDE_STEP);

    logic [CNT_W-1:0] count_next;

    // Compute the stepped count for the current transfer width.
    always_comb begin
        count_next = count + (step_wide ? INC_W : INC_N);
    end

    // Register the count: load first, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (step_en) begin
            count <= count_next;
        end
    end

    // Track completion: set on a step reaching zero, clear on reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (load_en) begin
            done <= 1'b0;
        end else if (step_en && (count_next == '0)) begin
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_addr_unit.sv
// Module: dma_addr_unit
// Holds the low address, the extension bits and the increment-inhibit bit,
// and advances the full address on a step unless inhibited and not forced.
// Assumes carries beyond the top extension bit are dropped.
module dma_addr_unit #(
    parameter int ADDR_W      = 16,
    parameter int EXT_W       = 2,
    parameter int NARROW_STEP = 2,
    parameter int WIDE_STEP   = 4,
    localparam int FULL_W     = ADDR_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wval,
    input  logic              ctrl_we,
    input  logic [EXT_W-1:0]  ext_wval,
    input  logic              inh_wval,
    input  logic              step_en,
    input  logic              step_wide,
    input  logic              force_inc,
    output logic [FULL_W-1:0] full_addr,
    output logic              inhibit
);

    localparam logic [FULL_W-1:0] INC_N = FULL_W'(NARROW_STEP);
    localparam logic [FULL_W-1:0] INC_W = FULL_W'(WIDE_STEP);

    logic [ADDR_W-1:0] base_q;
    logic [EXT_W-1:0]  ext_q;
    logic [FULL_W-1:0] addr_next;
    logic              write_back;

    // Form the full address and its stepped value.
    always_comb begin
        full_addr  = {ext_q, base_q};
        addr_next  = full_addr + (step_wide ? INC_W : INC_N);
        write_back = step_en && (!inhibit || force_inc);
    end

    // Low address: host write wins, else take the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (addr_we) begin
            base_q <= addr_wval;
        end else if (write_back) begin
            base_q <= addr_next[ADDR_W-1:0];
        end
    end

    // Extension bits: host write wins, else follow the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (ctrl_we) begin
            ext_q <= ext_wval;
        end else if (write_back) begin
            ext_q <= addr_next[FULL_W-1:ADDR_W];
        end
    end

    // Inhibit bit: written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
        end else if (ctrl_we) begin
            inhibit <= inh_wval;
        end
    end

endmodule

// File: rtl/dma_addr_counter.sv
// Module: dma_addr_counter (top)
// Address and word-count keeper for one transfer channel: decodes host
// register writes, gates transfer requests on a nonzero count, and steps
// count and address on each acknowledged access.
// Assumes the data width equals the count and address widths.
module dma_addr_counter #(
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 16,
    parameter int ADDR_W       = 16,
    parameter int EXT_W        = 2,
    parameter int CNT_STEP_N   = 1,
    parameter int CNT_STEP_W   = 2,
    parameter int ADDR_STEP_N  = 2,
    parameter int ADDR_STEP_W  = 4,
    localparam int FULL_W      = ADDR_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              xfer_req,
    input  logic              xfer_wide,
    input  logic              xfer_force,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_wide,
    output logic [FULL_W-1:0] bus_addr,
    output logic              zero_count,
    output logic [CNT_W-1:0]  word_count,
    output logic              incr_inhibit,
    output logic              done
);

    import dma_cnt_pkg::*;

    localparam int INH_BIT = EXT_W;

    logic cnt_we;
    logic adr_we;
    logic ctl_we;
    logic step_en;

    // Decode the host register select.
    always_comb begin
        cnt_we   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_COUNT);
        adr_we   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_ADDR);
        ctl_we   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
        bus_wide = xfer_wide;
    end

    dma_req_ctrl #(
        .CNT_W (CNT_W)
    ) u_req (
        .xfer_req   (xfer_req),
        .count      (word_count),
        .bus_ack    (bus_ack),
        .bus_req    (bus_req),
        .zero_count (zero_count),
        .step_en    (step_en)
    );

    dma_count_unit #(
        .CNT_W       (CNT_W),
        .NARROW_STEP (CNT_STEP_N),
        .WIDE_STEP   (CNT_STEP_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (cnt_we),
        .load_val  (CNT_W'(cfg_wdata)),
        .step_en   (step_en),
        .step_wide (xfer_wide),
        .count     (word_count),
        .done      (done)
    );

    dma_addr_unit #(
        .ADDR_W      (ADDR_W),
        .EXT_W       (EXT_W),
        .NARROW_STEP (ADDR_STEP_N),
        .WIDE_STEP   (ADDR_STEP_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (adr_we),
        .addr_wval (ADDR_W'(cfg_wdata)),
        .ctrl_we   (ctl_we),
        .ext_wval  (cfg_wdata[EXT_W-1:0]),
        .inh_wval  (cfg_wdata[INH_BIT]),
        .step_en   (step_en),
        .step_wide (xfer_wide),
        .force_inc (xfer_force),
        .full_addr (bus_addr),
        .inhibit   (incr_inhibit)
    );

endmodule

// File: rtl/dma_addr_counter_chk.sv
// Module: dma_addr_counter_chk
// Property checker bound to the top; watches only the top's ports.
module dma_addr_counter_chk #(
    parameter int CNT_W       = 16,
    parameter int FULL_W      = 18,
    parameter int CNT_STEP_N  = 1,
    parameter int CNT_STEP_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic              xfer_req,
    input logic              xfer_force,
    input logic              bus_ack,
    input logic              bus_req,
    input logic              bus_wide,
    input logic [FULL_W-1:0] bus_addr,
    input logic              zero_count,
    input logic [CNT_W-1:0]  word_count,
    input logic              incr_inhibit,
    input logic              done
);

    logic quiet_cfg;

    // True when no host write lands this cycle.
    always_comb begin
        quiet_cfg = !cfg_we;
    end

    a_r3_no_req_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '0) |-> (!bus_req && (zero_count == xfer_req)));

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && quiet_cfg) |=>
        (word_count == $past(word_count) +
            ($past(bus_wide) ? CNT_W'(CNT_STEP_W) : CNT_W'(CNT_STEP_N))));

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && incr_inhibit && !xfer_force && quiet_cfg)
        |=> $stable(bus_addr));

    a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (word_count == '0));

    a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && quiet_cfg) |=> ($stable(word_count) && $stable(bus_addr)));

endmodule

bind dma_addr_counter dma_addr_counter_chk #(
    .CNT_W      (CNT_W),
    .FULL_W     (FULL_W),
    .CNT_STEP_N (CNT_STEP_N),
    .CNT_STEP_W (CNT_STEP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .xfer_req     (xfer_req),
    .xfer_force   (xfer_force),
    .bus_ack      (bus_ack),
    .bus_req      (bus_req),
    .bus_wide     (bus_wide),
    .bus_addr     (bus_addr),
    .zero_count   (zero_count),
    .word_count   (word_count),
    .incr_inhibit (incr_inhibit),
    .done         (done)
);

// File: tb/tb_dma_addr_counter.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dma_addr_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        xfer_req = 1'b0;
    logic        xfer_wide = 1'b0;
    logic        xfer_force = 1'b0;
    logic        bus_ack = 1'b0;
    logic        bus_req;
    logic        bus_wide;
    logic [17:0] bus_addr;
    logic        zero_count;
    logic [15:0] word_count;
    logic        incr_inhibit;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    dma_addr_counter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .xfer_wide(xfer_wide),
        .xfer_force(xfer_force), .bus_ack(bus_ack), .bus_req(bus_req),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .zero_count(zero_count),
        .word_count(word_count), .incr_inhibit(incr_inhibit), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // One host register write; results visible at the following negedge.
    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One acknowledged transfer; results visible at the following negedge.
    task automatic xfer(input logic wide, input logic frc);
        @(negedge clk);
        xfer_req = 1'b1; xfer_wide = wide; xfer_force = frc; bus_ack = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0; bus_ack = 1'b0; xfer_force = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "count", word_count, 0);
        check("R1", "addr", bus_addr, 0);
        check("R1", "inhibit", incr_inhibit, 0);
        check("R1", "done", done, 0);
    endtask

    task automatic t_config();
        wr(2'd0, 16'hFFFD);
        wr(2'd1, 16'h1000);
        wr(2'd2, 16'h0001);
        check("R2", "count", word_count, 32'hFFFD);
        check("R2", "addr", bus_addr, 32'h11000);
        check("R2", "inhibit", incr_inhibit, 0);
    endtask

    task automatic t_narrow();
        @(negedge clk);
        xfer_req = 1'b1; xfer_wide = 1'b0;
        #1;
        check("R3", "bus_req nonzero", bus_req, 1);
        check("R3", "zero_count nonzero", zero_count, 0);
        bus_ack = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0; bus_ack = 1'b0;
        check("R4", "count", word_count, 32'hFFFE);
        check("R4", "addr", bus_addr, 32'h11002);
        check("R8", "done early", done, 0);
    endtask

    task automatic t_wide();
        xfer(1'b1, 1'b0);
        check("R5", "count", word_count, 0);
        check("R5", "addr", bus_addr, 32'h11006);
        check("R8", "done set", done, 1);
    endtask

    task automatic t_zero();
        @(negedge clk);
        xfer_req = 1'b1; xfer_wide = 1'b0; bus_ack = 1'b1;
        #1;
        check("R3", "bus_req at zero", bus_req, 0);
        check("R3", "zero_count", zero_count, 1);
        @(negedge clk);
        xfer_req = 1'b0; bus_ack = 1'b0;
        check("R3", "count held", word_count, 0);
        check("R3", "addr held", bus_addr, 32'h11006);
    endtask

    task automatic t_done_sticky();
        wr(2'd1, 16'h2000);
        check("R8", "done kept", done, 1);
        wr(2'd0, 16'hFFF0);
        check("R8", "done cleared", done, 0);
    endtask

    task automatic t_inhibit();
        wr(2'd2, 16'h0004);
        check("R6", "inhibit bit", incr_inhibit, 1);
        xfer(1'b0, 1'b0);
        check("R6", "addr inhibited", bus_addr, 32'h02000);
        check("R6", "count advances", word_count, 32'hFFF1);
        xfer(1'b0, 1'b1);
        check("R6", "addr forced", bus_addr, 32'h02002);
        check("R6", "count forced", word_count, 32'hFFF2);
    endtask

    task automatic t_carry();
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'hFFFE);
        xfer(1'b0, 1'b0);
        check("R7", "carry to ext", bus_addr, 32'h10000);
        wr(2'd2, 16'h0003);
        wr(2'd1, 16'hFFFC);
        xfer(1'b1, 1'b0);
        check("R7", "wrap top", bus_addr, 0);
        check("R7", "count", word_count, 32'hFFF5);
    endtask

    task automatic t_collide();
        @(negedge clk);
        xfer_req = 1'b1; xfer_wide = 1'b0; bus_ack = 1'b1;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h0005;
        @(negedge clk);
        xfer_req = 1'b0; bus_ack = 1'b0; cfg_we = 1'b0;
        check("R9", "load wins", word_count, 32'h0005);
        check("R9", "addr steps", bus_addr, 32'h00002);
    endtask

    task automatic t_stray();
        @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check("R10", "count", word_count, 32'h0005);
        check("R10", "addr", bus_addr, 32'h00002);
        check("R10", "done", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_narrow();
        t_wide();
        t_zero();
        t_done_sticky();
        t_inhibit();
        t_carry();
        t_collide();
        t_stray();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule